// File: doc/BRIEF.md
# Trap Entry State Save Unit

This unit performs the state bookkeeping of a processor trap entry in a single clock edge. When the trap strobe is high, it records the running context into the trap-stack registers for the new trap level. The saved context is the program counters, the packed status word, the hypervisor status and the trap type. In the same edge it computes the new trap level, the new global-register level, the new processor and hypervisor status words and the new register-window pointer. Choosing which trap to take and forming the handler address belong to neighbouring logic.

The entry mode comes from two plain control inputs. `red_i` selects a reset/error-mode entry and takes precedence over `hpriv_i`. `hpriv_i` selects an entry into hyperprivileged mode. With both low, the entry is into privileged mode. The strobe is a control pin with no back-pressure. The upstream sequencer guarantees that the register inputs are valid in the strobe cycle. Every output register loads on the edge that samples the strobe and holds its value until the next strobe. `upd_valid` pulses for one cycle after each load.

Top module: `trap_save_unit`

## Requirements
- R1: After reset, every output register, including `upd_valid`, is zero.
- R2: On a strobe, `tl_o` becomes `tl_i`+1 (modulo 2^3), `tt_o` takes `tt_i`, and `htstate_o` takes the old `hpstate_i`.
- R3: On a strobe, `tstate_o` holds the old GL in bits 42:40, CCR in 39:32, ASI in 31:24, the old 13-bit PSTATE in 20:8 and CWP zero-extended in 4:0. All other bits are zero.
- R4: If bit 3 (address mask) of `pstate_i` is set, `tpc_o`/`tnpc_o` get the low 32 bits of `pc_i`/`npc_i` with the upper bits zero. Otherwise they get the full 64-bit values.
- R5: `gl_o` becomes min(`gl_i`+1, 2) on a privileged entry, and min(`gl_i`+1, 3) on a hyperprivileged or RED entry.
- R6: On a non-RED entry, `pstate_o` equals `pstate_i` with bit 4 set and bits 3 and 1 cleared, apart from the mode changes in R7 and R8.
- R7: On a hyperprivileged entry, PSTATE bit 9 is cleared. HPSTATE bits 5 and 10 are cleared and bit 2 is set. All other HPSTATE bits, including bit 0, are kept.
- R8: On a privileged entry, PSTATE bit 2 is set, PSTATE bit 9 takes the value of bit 8, and `hpstate_o` equals `hpstate_i`.
- R9: On a RED entry (`red_i`=1, whatever `hpriv_i` is), `pstate_o` keeps only bit 2 of `pstate_i` and has bit 4 set. `hpstate_o` is `hpstate_i` with bits 5 and 2 set and bits 10 and 0 cleared.
- R10: `cwp_o` becomes `cwp_i`+1 for trap type 0x024, `cwp_i`+`cansave_i`+2 for types 0x080..0x0BF, and `cwp_i`-1 for types 0x0C0..0x0FF. The result is taken modulo 8 windows. For any other type it equals `cwp_i`.
- R11: `upd_valid` is high exactly in the cycle after a strobe. With no strobe, every output register keeps its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_go | input | 1 | Trap entry strobe |
| red_i | input | 1 | RED-mode entry select (dominant) |
| hpriv_i | input | 1 | Enter hyperprivileged mode |
| tt_i | input | 9 | Trap type |
| pc_i | input | 64 | Current PC |
| npc_i | input | 64 | Current next PC |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current address space identifier |
| cwp_i | input | 3 | Current window pointer |
| cansave_i | input | 3 | Savable window count |
| gl_i | input | 3 | Current global level |
| pstate_i | input | 13 | Current processor status |
| hpstate_i | input | 11 | Current hypervisor status |
| tl_i | input | 3 | Current trap level |
| upd_valid | output | 1 | One-cycle pulse after a load |
| tl_o | output | 3 | New trap level |
| gl_o | output | 3 | New global level |
| pstate_o | output | 13 | New processor status |
| hpstate_o | output | 11 | New hypervisor status |
| cwp_o | output | 3 | New window pointer |
| tstate_o | output | 64 | Packed saved status word |
| tpc_o | output | 64 | Saved PC |
| tnpc_o | output | 64 | Saved next PC |
| htstate_o | output | 11 | Saved hypervisor status |
| tt_o | output | 9 | Saved trap type |

## Verification
The bound checker checks these rules on every cycle:
- the strobe-to-pulse timing and register hold of R11;
- the trap-level step and trap-type capture of R2;
- the GL ceiling of R5;
- the fixed HPSTATE bits for hyperprivileged and RED entries in R7 and R9;
- that the window pointer is unchanged for trap types outside the three adjusting ranges (R10).

Only the directed scenarios can show the exact packed bit positions of the saved status word, the 32-bit address truncation, and the modulo wrap of the window pointer in both directions. They also show the bit-9 copy on privileged entries and the precedence of the RED flag over the hyperprivileged flag.

// File: rtl/trap_save_pkg.sv
package trap_save_pkg;
  localparam int PC_W   = 64;
  localparam int TT_W   = 9;
  localparam int PST_W  = 13;
  localparam int HPST_W = 11;
  localparam int TL_W   = 3;
  localparam int GL_W   = 3;
  localparam int CCR_W  = 8;
  localparam int ASI_W  = 8;
  localparam int TS_W   = 64;

  // packed saved-status field offsets
  localparam int TS_GL_LO  = 40;
  localparam int TS_CCR_LO = 32;
  localparam int TS_ASI_LO = 24;
  localparam int TS_PST_LO = 8;
  localparam int TS_CWP_LO = 0;

  // processor status bits
  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;

  // hypervisor status bits
  localparam int HP_TLZ  = 0;
  localparam int HP_HPRV = 2;
  localparam int HP_RED  = 5;
  localparam int HP_IBE  = 10;

  // window-adjusting trap types
  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [TT_W-1:0] TT_SPILL_LO  = 9'h080;
  localparam logic [TT_W-1:0] TT_SPILL_HI  = 9'h0BF;
  localparam logic [TT_W-1:0] TT_FILL_LO   = 9'h0C0;
  localparam logic [TT_W-1:0] TT_FILL_HI   = 9'h0FF;

  typedef enum logic [1:0] {
    ENTRY_PRIV = 2'd0,
    ENTRY_HYP  = 2'd1,
    ENTRY_RED  = 2'd2
  } entry_mode_e;
endpackage

// File: rtl/tsave_pack.sv
module tsave_pack
  import trap_save_pkg::*;
#(
  parameter int CWP_W = 3
) (
  input  logic [GL_W-1:0]  gl_i,
  input  logic [CCR_W-1:0] ccr_i,
  input  logic [ASI_W-1:0] asi_i,
  input  logic [PST_W-1:0] pstate_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  output logic [TS_W-1:0]  tstate_o,
  output logic [PC_W-1:0]  tpc_o,
  output logic [PC_W-1:0]  tnpc_o
);
  localparam int HI_W = PC_W - 32;

  always_comb begin
    tstate_o = '0;
    tstate_o[TS_GL_LO  +: GL_W]  = gl_i;
    tstate_o[TS_CCR_LO +: CCR_W] = ccr_i;
    tstate_o[TS_ASI_LO +: ASI_W] = asi_i;
    tstate_o[TS_PST_LO +: PST_W] = pstate_i;
    tstate_o[TS_CWP_LO +: CWP_W] = cwp_i;
  end

  // 32-bit address masking of the saved counters
  always_comb begin
    if (pstate_i[PS_AM]) begin
      tpc_o  = {{HI_W{1'b0}}, pc_i[31:0]};
      tnpc_o = {{HI_W{1'b0}}, npc_i[31:0]};
    end else begin
      tpc_o  = pc_i;
      tnpc_o = npc_i;
    end
  end
endmodule

// File: rtl/tsave_status.sv
module tsave_status
  import trap_save_pkg::*;
#(
  parameter int GL_MAX      = 3,
  parameter int GL_PRIV_MAX = 2
) (
  input  entry_mode_e       mode_i,
  input  logic [GL_W-1:0]   gl_i,
  input  logic [PST_W-1:0]  pstate_i,
  input  logic [HPST_W-1:0] hpstate_i,
  output logic [GL_W-1:0]   gl_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [HPST_W-1:0] hpstate_o
);
  int gl_inc;
  int gl_cap;

  always_comb begin
    gl_inc = int'(gl_i) + 1;
    gl_cap = (mode_i == ENTRY_PRIV) ? GL_PRIV_MAX : GL_MAX;
    gl_o   = (gl_inc > gl_cap) ? GL_W'(gl_cap) : GL_W'(gl_inc);
  end

  always_comb begin
    pstate_o  = pstate_i;
    hpstate_o = hpstate_i;
    unique case (mode_i)
      ENTRY_RED: begin
        pstate_o           = '0;
        pstate_o[PS_PRIV]  = pstate_i[PS_PRIV];
        pstate_o[PS_PEF]   = 1'b1;
        hpstate_o[HP_RED]  = 1'b1;
        hpstate_o[HP_HPRV] = 1'b1;
        hpstate_o[HP_IBE]  = 1'b0;
        hpstate_o[HP_TLZ]  = 1'b0;
      end
      ENTRY_HYP: begin
        pstate_o[PS_PEF]   = 1'b1;
        pstate_o[PS_AM]    = 1'b0;
        pstate_o[PS_IE]    = 1'b0;
        pstate_o[PS_CLE]   = 1'b0;
        hpstate_o[HP_RED]  = 1'b0;
        hpstate_o[HP_HPRV] = 1'b1;
        hpstate_o[HP_IBE]  = 1'b0;
      end
      default: begin
        pstate_o[PS_PEF]   = 1'b1;
        pstate_o[PS_AM]    = 1'b0;
        pstate_o[PS_IE]    = 1'b0;
        pstate_o[PS_PRIV]  = 1'b1;
        pstate_o[PS_CLE]   = pstate_i[PS_TLE];
      end
    endcase
  end
endmodule

// File: rtl/tsave_window.sv
module tsave_window
  import trap_save_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic [TT_W-1:0]  tt_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  output logic [CWP_W-1:0] cwp_o
);
  int step;
  int sum;

  always_comb begin
    if (tt_i == TT_CLEAN_WIN)
      step = 1;
    else if (tt_i >= TT_SPILL_LO && tt_i <= TT_SPILL_HI)
      step = int'(cansave_i) + 2;
    else if (tt_i >= TT_FILL_LO && tt_i <= TT_FILL_HI)
      step = NWIN - 1;
    else
      step = 0;
    sum   = int'(cwp_i) + step;
    cwp_o = CWP_W'(sum % NWIN);
  end
endmodule

// File: rtl/trap_save_unit.sv
module trap_save_unit
  import trap_save_pkg::*;
#(
  parameter int NWIN        = 8,
  parameter int GL_MAX      = 3,
  parameter int GL_PRIV_MAX = 2,
  localparam int CWP_W      = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_go,
  input  logic              red_i,
  input  logic              hpriv_i,
  input  logic [TT_W-1:0]   tt_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   npc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic [ASI_W-1:0]  asi_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [CWP_W-1:0]  cansave_i,
  input  logic [GL_W-1:0]   gl_i,
  input  logic [PST_W-1:0]  pstate_i,
  input  logic [HPST_W-1:0] hpstate_i,
  input  logic [TL_W-1:0]   tl_i,
  output logic              upd_valid,
  output logic [TL_W-1:0]   tl_o,
  output logic [GL_W-1:0]   gl_o,
  output logic [PST_W-1:0]  pstate_o,
  output logic [HPST_W-1:0] hpstate_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [TS_W-1:0]   tstate_o,
  output logic [PC_W-1:0]   tpc_o,
  output logic [PC_W-1:0]   tnpc_o,
  output logic [HPST_W-1:0] htstate_o,
  output logic [TT_W-1:0]   tt_o
);
  entry_mode_e       mode;
  logic [GL_W-1:0]   gl_nx;
  logic [PST_W-1:0]  pst_nx;
  logic [HPST_W-1:0] hpst_nx;
  logic [CWP_W-1:0]  cwp_nx;
  logic [TS_W-1:0]   ts_nx;
  logic [PC_W-1:0]   tpc_nx;
  logic [PC_W-1:0]   tnpc_nx;

  always_comb begin
    if (red_i)        mode = ENTRY_RED;
    else if (hpriv_i) mode = ENTRY_HYP;
    else              mode = ENTRY_PRIV;
  end

  tsave_pack #(.CWP_W(CWP_W)) u_pack (
    .gl_i(gl_i), .ccr_i(ccr_i), .asi_i(asi_i), .pstate_i(pstate_i),
    .cwp_i(cwp_i), .pc_i(pc_i), .npc_i(npc_i),
    .tstate_o(ts_nx), .tpc_o(tpc_nx), .tnpc_o(tnpc_nx)
  );

  tsave_status #(.GL_MAX(GL_MAX), .GL_PRIV_MAX(GL_PRIV_MAX)) u_status (
    .mode_i(mode), .gl_i(gl_i), .pstate_i(pstate_i), .hpstate_i(hpstate_i),
    .gl_o(gl_nx), .pstate_o(pst_nx), .hpstate_o(hpst_nx)
  );

  tsave_window #(.NWIN(NWIN), .CWP_W(CWP_W)) u_window (
    .tt_i(tt_i), .cwp_i(cwp_i), .cansave_i(cansave_i), .cwp_o(cwp_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      tl_o      <= '0;
      gl_o      <= '0;
      pstate_o  <= '0;
      hpstate_o <= '0;
      cwp_o     <= '0;
      tstate_o  <= '0;
      tpc_o     <= '0;
      tnpc_o    <= '0;
      htstate_o <= '0;
      tt_o      <= '0;
    end else begin
      upd_valid <= trap_go;
      if (trap_go) begin
        tl_o      <= tl_i + 1'b1;
        gl_o      <= gl_nx;
        pstate_o  <= pst_nx;
        hpstate_o <= hpst_nx;
        cwp_o     <= cwp_nx;
        tstate_o  <= ts_nx;
        tpc_o     <= tpc_nx;
        tnpc_o    <= tnpc_nx;
        htstate_o <= hpstate_i;
        tt_o      <= tt_i;
      end
    end
  end
endmodule

// File: rtl/trap_save_unit_chk.sv
module trap_save_unit_chk
  import trap_save_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int GL_MAX = 3,
  localparam int CWP_W = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_go,
  input logic              red_i,
  input logic              hpriv_i,
  input logic [TT_W-1:0]   tt_i,
  input logic [CWP_W-1:0]  cwp_i,
  input logic [TL_W-1:0]   tl_i,
  input logic              upd_valid,
  input logic [TL_W-1:0]   tl_o,
  input logic [GL_W-1:0]   gl_o,
  input logic [PST_W-1:0]  pstate_o,
  input logic [HPST_W-1:0] hpstate_o,
  input logic [CWP_W-1:0]  cwp_o,
  input logic [TS_W-1:0]   tstate_o,
  input logic [TT_W-1:0]   tt_o
);
  logic tt_keeps_win;
  assign tt_keeps_win = (tt_i != TT_CLEAN_WIN) && !(tt_i >= TT_SPILL_LO && tt_i <= TT_FILL_HI);

  AST_PULSE_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> upd_valid); // R11
  AST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_go |=> !upd_valid); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_go |=> $stable(tl_o) && $stable(tstate_o) && $stable(cwp_o) && $stable(tt_o)); // R11
  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> tl_o == $past(tl_i) + 1'b1); // R2
  AST_TT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> tt_o == $past(tt_i)); // R2
  AST_GL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gl_o) <= GL_MAX); // R5
  AST_HYP_HPSTATE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go && hpriv_i && !red_i |=> hpstate_o[HP_HPRV] && !hpstate_o[HP_RED] && !hpstate_o[HP_IBE] && !pstate_o[PS_CLE]); // R7
  AST_RED_HPSTATE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go && red_i |=> hpstate_o[HP_RED] && hpstate_o[HP_HPRV] && !hpstate_o[HP_IBE] && !hpstate_o[HP_TLZ]); // R9
  AST_WIN_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go && tt_keeps_win |=> cwp_o == $past(cwp_i)); // R10
endmodule

bind trap_save_unit trap_save_unit_chk #(.NWIN(NWIN), .GL_MAX(GL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_go(trap_go), .red_i(red_i), .hpriv_i(hpriv_i),
  .tt_i(tt_i), .cwp_i(cwp_i), .tl_i(tl_i), .upd_valid(upd_valid), .tl_o(tl_o),
  .gl_o(gl_o), .pstate_o(pstate_o), .hpstate_o(hpstate_o), .cwp_o(cwp_o),
  .tstate_o(tstate_o), .tt_o(tt_o)
);

// File: tb/trap_save_unit_bench.sv
module trap_save_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_go = 1'b0, red_i = 1'b0, hpriv_i = 1'b0;
  logic [8:0]  tt_i = '0;
  logic [63:0] pc_i = '0, npc_i = '0;
  logic [7:0]  ccr_i = '0, asi_i = '0;
  logic [2:0]  cwp_i = '0, cansave_i = '0, gl_i = '0, tl_i = '0;
  logic [12:0] pstate_i = '0;
  logic [10:0] hpstate_i = '0;

  logic        upd_valid;
  logic [2:0]  tl_o, gl_o, cwp_o;
  logic [12:0] pstate_o;
  logic [10:0] hpstate_o, htstate_o;
  logic [63:0] tstate_o, tpc_o, tnpc_o;
  logic [8:0]  tt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trap_save_unit u_trap_save_unit (
    .clk(clk), .rst_n(rst_n), .trap_go(trap_go), .red_i(red_i), .hpriv_i(hpriv_i),
    .tt_i(tt_i), .pc_i(pc_i), .npc_i(npc_i), .ccr_i(ccr_i), .asi_i(asi_i),
    .cwp_i(cwp_i), .cansave_i(cansave_i), .gl_i(gl_i), .pstate_i(pstate_i),
    .hpstate_i(hpstate_i), .tl_i(tl_i), .upd_valid(upd_valid), .tl_o(tl_o),
    .gl_o(gl_o), .pstate_o(pstate_o), .hpstate_o(hpstate_o), .cwp_o(cwp_o),
    .tstate_o(tstate_o), .tpc_o(tpc_o), .tnpc_o(tnpc_o), .htstate_o(htstate_o),
    .tt_o(tt_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one strobe with the current inputs and compare every output.
  // Expected values are written here from the requirement text.
  task automatic fire_and_check(input string name, input logic [2:0] exp_cwp);
    logic [63:0] e_ts, e_pc, e_npc;
    logic [12:0] e_ps;
    logic [10:0] e_hp;
    int          e_gl;
    string       ps_req;
    string       hp_req;
    e_ts = 64'(gl_i) << 40 | 64'(ccr_i) << 32 | 64'(asi_i) << 24 | 64'(pstate_i) << 8 | 64'(cwp_i);
    e_pc  = pstate_i[3] ? {32'h0, pc_i[31:0]}  : pc_i;
    e_npc = pstate_i[3] ? {32'h0, npc_i[31:0]} : npc_i;
    if (red_i) begin
      e_ps = 13'h010 | (pstate_i & 13'h004);
      e_hp = (hpstate_i | 11'h024) & ~11'h401;
      e_gl = (gl_i + 1 > 3) ? 3 : gl_i + 1;
      ps_req = "R9"; hp_req = "R9";
    end else if (hpriv_i) begin
      e_ps = (pstate_i | 13'h010) & ~13'h20A;
      e_hp = (hpstate_i | 11'h004) & ~11'h420;
      e_gl = (gl_i + 1 > 3) ? 3 : gl_i + 1;
      ps_req = "R6/R7"; hp_req = "R7";
    end else begin
      e_ps = (pstate_i | 13'h014) & ~13'h20A;
      e_ps[9] = pstate_i[8];
      e_hp = hpstate_i;
      e_gl = (gl_i + 1 > 2) ? 2 : gl_i + 1;
      ps_req = "R6/R8"; hp_req = "R8";
    end
    @(negedge clk);
    trap_go = 1'b1;
    @(negedge clk);
    trap_go = 1'b0;
    chk("R11", {name, " upd_valid"}, 64'(upd_valid), 64'd1);
    chk("R2",  {name, " tl"},        64'(tl_o),      64'(3'(tl_i + 3'd1)));
    chk("R2",  {name, " tt"},        64'(tt_o),      64'(tt_i));
    chk("R2",  {name, " htstate"},   64'(htstate_o), 64'(hpstate_i));
    chk("R3",  {name, " tstate"},    tstate_o,       e_ts);
    chk("R4",  {name, " tpc"},       tpc_o,          e_pc);
    chk("R4",  {name, " tnpc"},      tnpc_o,         e_npc);
    chk("R5",  {name, " gl"},        64'(gl_o),      64'(e_gl));
    chk(ps_req, {name, " pstate"},   64'(pstate_o),  64'(e_ps));
    chk(hp_req, {name, " hpstate"},  64'(hpstate_o), 64'(e_hp));
    chk("R10", {name, " cwp"},       64'(cwp_o),     64'(exp_cwp));
    @(negedge clk);
    chk("R11", {name, " pulse ends"}, 64'(upd_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "upd_valid", 64'(upd_valid), 0);
    chk("R1", "tl",        64'(tl_o), 0);
    chk("R1", "gl",        64'(gl_o), 0);
    chk("R1", "pstate",    64'(pstate_o), 0);
    chk("R1", "hpstate",   64'(hpstate_o), 0);
    chk("R1", "cwp",       64'(cwp_o), 0);
    chk("R1", "tstate",    tstate_o, 0);
    chk("R1", "tpc",       tpc_o, 0);
    chk("R1", "tnpc",      tnpc_o, 0);
    chk("R1", "htstate",   64'(htstate_o), 0);
    chk("R1", "tt",        64'(tt_o), 0);
  endtask

  // privileged clean-window trap, address mask set, CWP wraps 7 -> 0
  task automatic t_priv_clean();
    red_i = 0; hpriv_i = 0; tt_i = 9'h024;
    pc_i = 64'hDEAD_BEEF_1234_5678; npc_i = 64'hCAFE_F00D_1234_567C;
    ccr_i = 8'hA5; asi_i = 8'h3C; cwp_i = 3'd7; cansave_i = 3'd2;
    gl_i = 3'd0; tl_i = 3'd1; pstate_i = 13'h10B; hpstate_i = 11'h401;
    fire_and_check("priv_clean", 3'd0);
  endtask

  // privileged GL saturation at 2, bit8 clear copies to bit9, no window change
  task automatic t_priv_gl_sat();
    red_i = 0; hpriv_i = 0; tt_i = 9'h010;
    pc_i = 64'h0000_0001_0000_0040; npc_i = 64'h0000_0001_0000_0044;
    ccr_i = 8'h0F; asi_i = 8'h80; cwp_i = 3'd3; cansave_i = 3'd5;
    gl_i = 3'd2; tl_i = 3'd2; pstate_i = 13'h0200; hpstate_i = 11'h000;
    fire_and_check("priv_gl_sat", 3'd3);
  endtask

  // hyperprivileged spill: CWP + CANSAVE + 2 wraps, full 64-bit PC, TLZ kept
  task automatic t_hyp_spill();
    red_i = 0; hpriv_i = 1; tt_i = 9'h085;
    pc_i = 64'hFFFF_0000_AAAA_5550; npc_i = 64'hFFFF_0000_AAAA_5554;
    ccr_i = 8'h11; asi_i = 8'h14; cwp_i = 3'd5; cansave_i = 3'd6;
    gl_i = 3'd2; tl_i = 3'd3; pstate_i = 13'h1F16; hpstate_i = 11'h425;
    fire_and_check("hyp_spill", 3'd5);
  endtask

  // hyperprivileged trap type 0x100 leaves CWP, GL saturates at 3
  task automatic t_hyp_other();
    red_i = 0; hpriv_i = 1; tt_i = 9'h100;
    pc_i = 64'h0123_4567_89AB_CDE0; npc_i = 64'h0123_4567_89AB_CDE4;
    ccr_i = 8'hFF; asi_i = 8'h00; cwp_i = 3'd6; cansave_i = 3'd1;
    gl_i = 3'd3; tl_i = 3'd7; pstate_i = 13'h0008; hpstate_i = 11'h000;
    fire_and_check("hyp_other", 3'd6);
  endtask

  // RED entry wins over hpriv flag, fill trap wraps CWP 0 -> 7
  task automatic t_red_fill();
    red_i = 1; hpriv_i = 1; tt_i = 9'h0C5;
    pc_i = 64'h0000_00FF_F000_0020; npc_i = 64'h0000_00FF_F000_0024;
    ccr_i = 8'h5A; asi_i = 8'hC3; cwp_i = 3'd0; cansave_i = 3'd0;
    gl_i = 3'd1; tl_i = 3'd4; pstate_i = 13'h1FFF; hpstate_i = 11'h3DB;
    fire_and_check("red_fill", 3'd7);
  endtask

  // RED with spill at the upper end of the range
  task automatic t_red_spill_top();
    red_i = 1; hpriv_i = 0; tt_i = 9'h0BF;
    pc_i = 64'h8000_0000_0000_0000; npc_i = 64'h8000_0000_0000_0004;
    ccr_i = 8'h01; asi_i = 8'h02; cwp_i = 3'd1; cansave_i = 3'd7;
    gl_i = 3'd3; tl_i = 3'd5; pstate_i = 13'h0000; hpstate_i = 11'h7FF;
    fire_and_check("red_spill_top", 3'd2);
  endtask

  // without a strobe, changing inputs must not move any output
  task automatic t_idle_hold();
    logic [63:0] s_ts, s_pc;
    logic [12:0] s_ps;
    logic [2:0]  s_tl, s_cwp, s_gl;
    s_ts = tstate_o; s_pc = tpc_o; s_ps = pstate_o; s_tl = tl_o; s_cwp = cwp_o; s_gl = gl_o;
    red_i = 0; hpriv_i = 1; tt_i = 9'h024; pc_i = '1; npc_i = '1;
    pstate_i = '1; cwp_i = 3'd4; gl_i = 3'd0; tl_i = 3'd0; ccr_i = '1;
    repeat (3) @(negedge clk);
    chk("R11", "idle tstate", tstate_o, s_ts);
    chk("R11", "idle tpc",    tpc_o,    s_pc);
    chk("R11", "idle pstate", 64'(pstate_o), 64'(s_ps));
    chk("R11", "idle tl",     64'(tl_o), 64'(s_tl));
    chk("R11", "idle cwp",    64'(cwp_o), 64'(s_cwp));
    chk("R11", "idle gl",     64'(gl_o), 64'(s_gl));
    chk("R11", "idle pulse",  64'(upd_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_priv_clean();
    t_priv_gl_sat();
    t_hyp_spill();
    t_hyp_other();
    t_red_fill();
    t_red_spill_top();
    t_idle_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule